// File: doc/BRIEF.md
# Two-Level Time-Slotted Bus Arbiter

This block decides which of N masters owns a shared on-chip bus for the next transfer. It works on two levels. The first level is a circular table of time slots, and each slot names one master. The master that owns the current slot always wins if it is requesting, so every slot owner gets a guaranteed share of the bus. If the slot owner is idle, the tenure goes to a second-level policy. That policy is either fixed priority or round-robin, and it is selected at run time.

The decision for the next tenure is computed every cycle while the current transfer runs. It is loaded on the cycle where the master signals the end of the transfer, so back-to-back transfers leave no dead cycle on the bus. Software can rewrite the slot owners, the per-master priorities and the fallback policy through a single write port while the bus is running. Each write goes into a staging copy. The staging copy becomes the live copy only at a transfer boundary, so the configuration never changes in the middle of a tenure.

Top module: `tdm_bus_arbiter`

## Requirements
- R1: After reset, `gnt` and `gnt_valid` are 0 and the slot pointer is 0. Slot i belongs to master i mod N, every priority is 0, the fallback policy is round-robin and the round-robin pointer is 0.
- R2: `gnt` is one-hot while `gnt_valid` is 1 and all-zero while it is 0. Bit i of `gnt` means master i holds the bus.
- R3: A boundary cycle is a cycle where the bus is idle or `xfer_done` is 1. In a boundary cycle where any `req` bit is set, a grant to a requesting master is present on the next cycle. In a boundary cycle with no request, the bus is idle on the next cycle.
- R4: While a tenure runs and `xfer_done` is 0, `gnt` does not change. When `xfer_done` is 1 and a request is pending, the next grant is present on the very next cycle with no idle cycle in between.
- R5: The owner of the slot that the slot pointer selects wins whenever it is requesting. The pointer advances by one on each completed transfer (`xfer_done` while granted) and wraps from the last slot to 0. An `xfer_done` pulse while the bus is idle does not advance it. A new tenure uses the slot after the current one, and a grant from idle uses the current slot.
- R6: In round-robin mode, when the slot owner is not requesting, the winner is the first requesting master found searching upward, with wrap, from the round-robin pointer. On every grant, from either level, the pointer becomes one past the granted master, modulo N.
- R7: In fixed-priority mode, when the slot owner is not requesting, the requesting master with the largest priority value wins. Among masters with equal priority, the lowest index wins.
- R8: A write with `cfg_we`=1 works as follows. Address s < N_SLOT sets the owner of slot s to the low bits of `cfg_wdata`. Address N_SLOT+m sets the priority of master m. Address N_SLOT+N sets the policy: bit 0 = 1 selects fixed priority and bit 0 = 0 selects round-robin.
- R9: Writes update only the staging copy. The live copy, which the arbitration reads, is loaded from the staging copy at the clock edge that ends each boundary cycle. As a result, a write made during a tenure does not affect the decision taken at the end of that same tenure, and it does affect the next decision.
- R10: With N=1 the lone master is granted on the cycle after it requests, and no table lookup or fallback is involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | N_MST | One request bit per master |
| xfer_done | input | 1 | One-cycle pulse marking the last cycle of the current transfer |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration address (slots, then priorities, then policy) |
| cfg_wdata | input | CFG_DW | Configuration write data |
| gnt | output | N_MST | One-hot grant |
| gnt_valid | output | 1 | A grant is active |

## Verification
The assertions assume that `xfer_done` is pulsed only while the grant is active, or else is ignored. They also assume that `req` changes only between clock edges. The bench drives every input on the falling edge and raises `xfer_done` for exactly one cycle inside a running tenure, except in the one test that pulses it on an idle bus on purpose. Configuration writes made while the bus is idle are followed by one settling cycle before any request, so the live copy already holds them. A single write test is placed inside a tenure to expose the staging delay.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;

  typedef enum logic {
    POL_RR    = 1'b0,
    POL_FIXED = 1'b1
  } fb_policy_e;

endpackage

// File: rtl/tdm_arb_rst_sync.sv
module tdm_arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/tdm_arb_cfg.sv
module tdm_arb_cfg
  import tdm_arb_pkg::*;
#(
  parameter int N_MST  = 4,
  parameter int N_SLOT = 8,
  parameter int PRIO_W = 2,
  parameter int IDX_W  = 2,
  parameter int AW     = 4,
  parameter int DW     = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [AW-1:0]                     wr_addr,
  input  logic [DW-1:0]                     wr_data,
  input  logic                              apply,
  output logic [N_SLOT-1:0][IDX_W-1:0]      live_owner,
  output logic [N_MST-1:0][PRIO_W-1:0]      live_prio,
  output fb_policy_e                        live_pol
);

  localparam int PRIO_BASE = N_SLOT;
  localparam int POL_ADDR  = N_SLOT + N_MST;

  logic [N_SLOT-1:0][IDX_W-1:0] stg_owner_q, stg_owner_d;
  logic [N_MST-1:0][PRIO_W-1:0] stg_prio_q, stg_prio_d;
  fb_policy_e                   stg_pol_q, stg_pol_d;

  logic [N_SLOT-1:0][IDX_W-1:0] live_owner_q;
  logic [N_MST-1:0][PRIO_W-1:0] live_prio_q;
  fb_policy_e                   live_pol_q;

  // staging next state
  always_comb begin
    stg_owner_d = stg_owner_q;
    stg_prio_d  = stg_prio_q;
    stg_pol_d   = stg_pol_q;
    for (int s = 0; s < N_SLOT; s++) begin
      if (int'(wr_addr) == s) stg_owner_d[s] = wr_data[IDX_W-1:0];
    end
    for (int m = 0; m < N_MST; m++) begin
      if (int'(wr_addr) == PRIO_BASE + m) stg_prio_d[m] = wr_data[PRIO_W-1:0];
    end
    if (int'(wr_addr) == POL_ADDR) stg_pol_d = fb_policy_e'(wr_data[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SLOT; s++) stg_owner_q[s] <= IDX_W'(s % N_MST);
      stg_prio_q <= '0;
      stg_pol_q  <= POL_RR;
    end else if (wr_en) begin
      stg_owner_q <= stg_owner_d;
      stg_prio_q  <= stg_prio_d;
      stg_pol_q   <= stg_pol_d;
    end
  end

  // live copy, loaded only at transfer boundaries
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SLOT; s++) live_owner_q[s] <= IDX_W'(s % N_MST);
      live_prio_q <= '0;
      live_pol_q  <= POL_RR;
    end else if (apply) begin
      live_owner_q <= stg_owner_q;
      live_prio_q  <= stg_prio_q;
      live_pol_q   <= stg_pol_q;
    end
  end

  assign live_owner = live_owner_q;
  assign live_prio  = live_prio_q;
  assign live_pol   = live_pol_q;

endmodule

// File: rtl/tdm_arb_fallback.sv
module tdm_arb_fallback
  import tdm_arb_pkg::*;
#(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 2,
  parameter int IDX_W  = 2
) (
  input  logic [N_MST-1:0]              req,
  input  logic [N_MST-1:0][PRIO_W-1:0]  prio,
  input  fb_policy_e                    pol,
  input  logic [IDX_W-1:0]              rr_ptr,
  output logic [IDX_W-1:0]              win
);

  always_comb begin
    int              idx;
    logic            hit;
    logic [PRIO_W-1:0] best;
    hit  = 1'b0;
    best = '0;
    idx  = 0;
    win  = '0;
    if (pol == POL_FIXED) begin
      // strict greater-than keeps the lowest index on a tie
      for (int i = 0; i < N_MST; i++) begin
        if (req[i] && (!hit || prio[i] > best)) begin
          hit  = 1'b1;
          best = prio[i];
          win  = IDX_W'(i);
        end
      end
    end else begin
      for (int k = 0; k < N_MST; k++) begin
        idx = int'(rr_ptr) + k;
        if (idx >= N_MST) idx = idx - N_MST;
        if (!hit && req[idx]) begin
          hit = 1'b1;
          win = IDX_W'(idx);
        end
      end
    end
  end

endmodule

// File: rtl/tdm_bus_arbiter.sv
module tdm_bus_arbiter
  import tdm_arb_pkg::*;
#(
  parameter  int N_MST  = 4,
  parameter  int N_SLOT = 8,
  parameter  int PRIO_W = 2,
  localparam int IDX_W  = (N_MST > 1) ? $clog2(N_MST) : 1,
  localparam int CFG_AW = $clog2(N_SLOT + N_MST + 1),
  localparam int CFG_DW = (IDX_W > PRIO_W) ? IDX_W : PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MST-1:0]  req,
  input  logic              xfer_done,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [N_MST-1:0]  gnt,
  output logic              gnt_valid
);

  localparam int SW = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;

  logic rst_n_sync;

  logic             gnt_vld_q;
  logic [IDX_W-1:0] gnt_idx_q;
  logic [SW-1:0]    slot_q, slot_inc, eval_slot;
  logic [IDX_W-1:0] rr_q;

  logic             boundary, grant_en, slot_en, rr_en;
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx, rr_nxt;

  logic [N_SLOT-1:0][IDX_W-1:0] live_owner;
  logic [N_MST-1:0][PRIO_W-1:0] live_prio;
  fb_policy_e                   live_pol;

  tdm_arb_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  tdm_arb_cfg #(
    .N_MST(N_MST), .N_SLOT(N_SLOT), .PRIO_W(PRIO_W),
    .IDX_W(IDX_W), .AW(CFG_AW), .DW(CFG_DW)
  ) i_cfg (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .wr_en      (cfg_we),
    .wr_addr    (cfg_addr),
    .wr_data    (cfg_wdata),
    .apply      (boundary),
    .live_owner (live_owner),
    .live_prio  (live_prio),
    .live_pol   (live_pol)
  );

  // boundary and slot sequencing
  always_comb begin
    boundary  = !gnt_vld_q || xfer_done;
    slot_inc  = (slot_q == SW'(N_SLOT - 1)) ? '0 : slot_q + 1'b1;
    eval_slot = gnt_vld_q ? slot_inc : slot_q;
    pick_any  = |req;
  end

  generate
    if (N_MST == 1) begin : g_single
      // no contention possible: the lone requester is the winner
      assign pick_idx = '0;
      assign rr_nxt   = '0;
    end else begin : g_multi
      logic [IDX_W-1:0] owner;
      logic             owner_ok;
      logic [IDX_W-1:0] fb_win;

      tdm_arb_fallback #(
        .N_MST(N_MST), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
      ) i_fallback (
        .req    (req),
        .prio   (live_prio),
        .pol    (live_pol),
        .rr_ptr (rr_q),
        .win    (fb_win)
      );

      always_comb begin
        owner    = live_owner[eval_slot];
        owner_ok = 1'b0;
        if (int'(owner) < N_MST) owner_ok = req[owner];
        pick_idx = owner_ok ? owner : fb_win;
        rr_nxt   = (pick_idx == IDX_W'(N_MST - 1)) ? '0 : pick_idx + 1'b1;
      end
    end
  endgenerate

  // clock enables
  always_comb begin
    grant_en = boundary;
    slot_en  = gnt_vld_q && xfer_done;
    rr_en    = boundary && pick_any;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      gnt_vld_q <= 1'b0;
      gnt_idx_q <= '0;
    end else if (grant_en) begin
      gnt_vld_q <= pick_any;
      gnt_idx_q <= pick_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  slot_q <= '0;
    else if (slot_en) slot_q <= slot_inc;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) rr_q <= '0;
    else if (rr_en)  rr_q <= rr_nxt;
  end

  always_comb begin
    for (int i = 0; i < N_MST; i++) gnt[i] = gnt_vld_q && (gnt_idx_q == IDX_W'(i));
    gnt_valid = gnt_vld_q;
  end

endmodule

// File: rtl/tdm_arb_chk.sv
module tdm_arb_chk #(
  parameter int N_MST = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MST-1:0] req,
  input logic             xfer_done,
  input logic [N_MST-1:0] gnt,
  input logic             gnt_valid
);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R2

  AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid && (|req)) |=> gnt_valid); // R3

  AST_NO_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((!gnt_valid || xfer_done) && (req == '0)) |=> !gnt_valid); // R3

  AST_GNT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((!gnt_valid || xfer_done) && (|req)) |=> ((gnt & $past(req)) != '0)); // R3

  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !xfer_done) |=> (gnt_valid && $stable(gnt))); // R4

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && xfer_done && (|req)) |=> gnt_valid); // R4

endmodule

bind tdm_bus_arbiter tdm_arb_chk #(.N_MST(N_MST)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .req       (req),
  .xfer_done (xfer_done),
  .gnt       (gnt),
  .gnt_valid (gnt_valid)
);

// File: tb/test_tdm_bus_arbiter.sv
module test_tdm_bus_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 20000;
  localparam int NM         = 4;
  localparam int NS         = 8;
  localparam int POL_A      = NS + NM;   // policy address
  localparam int PRI_A      = NS;        // priority base address

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NM-1:0] req;
  logic          xfer_done;
  logic          cfg_we;
  logic [3:0]    cfg_addr;
  logic [1:0]    cfg_wdata;
  logic [NM-1:0] gnt;
  logic          gnt_valid;

  logic          req1, done1, gnt1, vld1;

  int checks   = 0;
  int failures = 0;
  int expq[$];
  bit mon_en   = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_bus_arbiter #(.N_MST(NM), .N_SLOT(NS), .PRIO_W(2)) i_tdm_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .xfer_done(xfer_done),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .gnt(gnt), .gnt_valid(gnt_valid)
  );

  tdm_bus_arbiter #(.N_MST(1), .N_SLOT(NS), .PRIO_W(2)) i_tdm_bus_arbiter_single (
    .clk(clk), .rst_n(rst_n), .req(req1), .xfer_done(done1),
    .cfg_we(1'b0), .cfg_addr('0), .cfg_wdata('0),
    .gnt(gnt1), .gnt_valid(vld1)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [NM-1:0] g);
    int r = -1;
    for (int i = 0; i < NM; i++) if (g[i]) r = i;
    return r;
  endfunction

  // monitor: pops an expected tenure owner (or -1 for idle) at every boundary result
  logic          prev_valid = 1'b0;
  logic [NM-1:0] prev_gnt   = '0;
  always @(posedge clk) begin
    #1;
    if (mon_en) begin
      int act, e;
      act = gnt_valid ? idx_of(gnt) : -1;
      if ((prev_valid && xfer_done) || (!prev_valid && gnt_valid)) begin
        if (expq.size() == 0) begin
          check(1'b0, "R5/R6/R7 unexpected tenure", act, -2);
        end else begin
          e = expq.pop_front();
          check((act == e) && ((gnt_valid == 1'b1) == (gnt != '0)),
                "R4/R5/R6/R7/R9 tenure owner", act, e);
        end
      end else if (prev_valid) begin
        check(gnt_valid && (gnt == prev_gnt), "R4 grant hold", idx_of(gnt), idx_of(prev_gnt));
      end
      prev_valid = gnt_valid;
      prev_gnt   = gnt;
    end
  end

  task automatic cfg_wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 2'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start(input logic [NM-1:0] r, input int exp);
    expq.push_back(exp);
    @(negedge clk);
    req = r;
  endtask

  task automatic end_tenure(input int hold, input logic [NM-1:0] nreq, input int exp);
    expq.push_back(exp);
    repeat (hold) @(negedge clk);
    xfer_done = 1'b1; req = nreq;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = '0; xfer_done = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req1 = 1'b0; done1 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(gnt == '0 && !gnt_valid, "R1 reset grant", int'(gnt), 0);
    check(gnt1 == 1'b0 && !vld1, "R1 reset grant single", int'(gnt1), 0);
    mon_en = 1'b1;

    // R1/R5: default table, all requesting -> 0,1,2,3,0 ; then idle (R3)
    start(4'b1111, 0);
    end_tenure(2, 4'b1111, 1);
    end_tenure(1, 4'b1111, 2);
    end_tenure(3, 4'b1111, 3);
    end_tenure(1, 4'b1111, 0);
    end_tenure(2, 4'b0000, -1);
    repeat (2) @(negedge clk);
    check(gnt == '0 && !gnt_valid, "R3 idle without request", int'(gnt), 0);

    // R6: round-robin fallback, slot wrap (R5): 2,2,3,2,3
    start(4'b1100, 2);
    end_tenure(1, 4'b1100, 2);
    end_tenure(1, 4'b1100, 3);
    end_tenure(1, 4'b1100, 2);
    end_tenure(1, 4'b1100, 3);
    end_tenure(1, 4'b0000, -1);

    // R8: fixed priority, m1=3, m3=1 ; R7
    cfg_wr(POL_A, 1);
    cfg_wr(PRI_A + 1, 3);
    cfg_wr(PRI_A + 3, 1);
    @(negedge clk);
    start(4'b1010, 1);
    end_tenure(1, 4'b1010, 3);
    end_tenure(1, 4'b1010, 1);
    end_tenure(1, 4'b1010, 1);
    end_tenure(1, 4'b0000, -1);
    // R7: priority value beats lower index
    start(4'b1001, 3);
    end_tenure(2, 4'b0000, -1);

    // R9: writes during a tenure are staged
    start(4'b0001, 0);
    cfg_wr(0, 2);
    cfg_wr(1, 2);
    end_tenure(1, 4'b0101, 0);   // old slot 0 owner still used
    end_tenure(1, 4'b0101, 2);   // new slot 1 owner now live
    end_tenure(1, 4'b0000, -1);

    // R5: done pulses while idle do not move the slot pointer
    repeat (2) begin
      @(negedge clk); xfer_done = 1'b1;
      @(negedge clk); xfer_done = 1'b0;
    end
    check(!gnt_valid, "R5 idle done ignored (no grant)", int'(gnt_valid), 0);
    start(4'b1001, 3);
    end_tenure(1, 4'b0000, -1);

    // R6: pure round-robin rotation with no slot owner requesting
    cfg_wr(POL_A, 0);
    for (int s = 0; s < NS; s++) cfg_wr(s, 3);
    @(negedge clk);
    start(4'b0111, 0);
    end_tenure(1, 4'b0111, 1);
    end_tenure(1, 4'b0111, 2);
    end_tenure(1, 4'b0111, 0);
    end_tenure(1, 4'b0111, 1);
    end_tenure(1, 4'b0000, -1);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R4 all expected tenures seen", expq.size(), 0);

    // R10: single master
    req1 = 1'b1;
    @(negedge clk);
    check(gnt1 == 1'b1 && vld1, "R10 lone master granted", int'(gnt1), 1);
    done1 = 1'b1;
    @(negedge clk);
    done1 = 1'b0;
    check(gnt1 == 1'b1 && vld1, "R10 lone master regranted", int'(gnt1), 1);
    done1 = 1'b1; req1 = 1'b0;
    @(negedge clk);
    done1 = 1'b0;
    check(gnt1 == 1'b0 && !vld1, "R10 lone master released", int'(gnt1), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule